// File: doc/BRIEF.md
# Predicate Mask Shadow Unit

This block keeps a hold over a group of element-level function units that the issue logic has already started speculatively for a predicated vector-style operation. One instance serves one predicate mask register. The issue logic first hands over an element-to-unit mapping. The block then waits until the mask value arrives, already read and decoded. In the cycle after that, it resolves every mapped element at once. If an element's mask bit is clear, its unit receives a go-die pulse and drops the operation. If the bit is set, its unit receives a success pulse, which lifts its write hold.

Two interfaces carry data, and both use valid/ready. A transfer happens on a rising clock edge where valid and ready are both high. The allocation interface is ready only while the unit is idle. The mask interface is ready only while the unit waits for a mask. The source may hold valid high for any number of cycles while ready is low; nothing is consumed during that time. The flush input is a plain control pin. A flush during the wait kills every mapped unit. Reading the register file happens outside this block.

Top module: `pred_shadow_unit`

## Requirements
- R1: After reset the unit is idle. `busy` is 0, `alloc_ready` is 1, `mask_ready` is 0, and every bit of `go_die` and `success` is 0.
- R2: An allocation transfer stores `alloc_elem_en` and `alloc_map`. Element e maps to the function unit whose index is `alloc_map[e*IDX_W +: IDX_W]`. From the next cycle, `busy` is 1 and `alloc_ready` is 0. While the unit is busy, `alloc_valid` has no effect on the stored mapping.
- R3: `mask_ready` is 1 only while waiting for a mask. A `mask_valid` while not waiting produces no output pulse.
- R4: For each mapped element whose `mask_bits[e]` is 0, `go_die` of its unit is 1 for exactly the one cycle after the mask transfer.
- R5: For each mapped element whose `mask_bits[e]` is 1, `success` of its unit is 1 for exactly the one cycle after the mask transfer.
- R6: Mask bits of unmapped elements are ignored. A unit that no mapped element targets receives neither pulse.
- R7: `flush` while waiting for a mask pulses `go_die` for every mapped unit in the next cycle and gives no `success`. This holds even if a mask transfer happens in the same cycle.
- R8: A unit never sees `go_die` and `success` together. The cycle after the decision pulse, `busy` is 0 and a new allocation is accepted.
- R9: `flush` while idle has no effect: no pulse, and `busy` stays 0.

Top module ports follow.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| alloc_valid | input | 1 | Allocation offered |
| alloc_ready | output | 1 | Allocation can be taken (unit idle) |
| alloc_elem_en | input | NUM_ELEM | Element has an allocated unit |
| alloc_map | input | NUM_ELEM*IDX_W | Unit index per element, element e at bits e*IDX_W |
| mask_valid | input | 1 | Decoded mask offered |
| mask_ready | output | 1 | Waiting for the mask |
| mask_bits | input | NUM_ELEM | Predicate mask, bit e for element e |
| flush | input | 1 | Cancel the pending wait |
| busy | output | 1 | Unit allocated; blocks reallocation |
| go_die | output | NUM_FU | Per-unit cancel pulse |
| success | output | NUM_FU | Per-unit release pulse |

## Verification
Each allocation shows up as `busy` exactly one cycle after its transfer edge. The mask decisions, and a flush in the wait state, drive `go_die` and `success` one cycle after the edge that takes them. The return to idle comes one cycle after that. Each check drives inputs at a falling edge and reads the outputs at the falling edge that follows the edge named above. Later checks verify that the pulses have dropped and that the stored mapping was left unchanged.

// File: rtl/pred_shadow_pkg.sv
package pred_shadow_pkg;
  typedef enum logic [1:0] {
    PS_IDLE      = 2'd0,
    PS_WAIT_MASK = 2'd1,
    PS_RESOLVE   = 2'd2
  } ps_state_e;
endpackage

// File: rtl/pred_shadow_ctrl.sv
module pred_shadow_ctrl
  import pred_shadow_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic alloc_valid,
  input  logic mask_valid,
  input  logic flush,
  output logic alloc_ready,
  output logic mask_ready,
  output logic busy,
  output logic alloc_fire,
  output logic decide_fire,
  output logic decide_kill_all
);
  ps_state_e state_q, state_d;

  assign alloc_ready     = (state_q == PS_IDLE);
  assign mask_ready      = (state_q == PS_WAIT_MASK);
  assign busy            = (state_q != PS_IDLE);
  assign alloc_fire      = alloc_valid && alloc_ready;
  assign decide_fire     = mask_ready && (mask_valid || flush);
  assign decide_kill_all = mask_ready && flush;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      PS_IDLE:      if (alloc_fire)  state_d = PS_WAIT_MASK;
      PS_WAIT_MASK: if (decide_fire) state_d = PS_RESOLVE;
      PS_RESOLVE:                    state_d = PS_IDLE;
      default:                       state_d = PS_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) state_q <= PS_IDLE;
    else        state_q <= state_d;
  end

  AST_BUSY_FROM_ALLOC: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(alloc_valid)); // R2
  AST_RESOLVE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == PS_RESOLVE) |=> !busy); // R8
  AST_FLUSH_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && flush && !alloc_valid) |=> !busy); // R9
endmodule

// File: rtl/pred_shadow_map_reg.sv
module pred_shadow_map_reg #(
  parameter int NUM_ELEM = 8,
  parameter int IDX_W    = 4
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      load,
  input  logic [NUM_ELEM-1:0]       en_in,
  input  logic [NUM_ELEM*IDX_W-1:0] map_in,
  output logic [NUM_ELEM-1:0]       en_q,
  output logic [NUM_ELEM*IDX_W-1:0] map_q
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      en_q  <= '0;
      map_q <= '0;
    end else if (load) begin
      en_q  <= en_in;
      map_q <= map_in;
    end
  end
endmodule

// File: rtl/pred_shadow_decode.sv
module pred_shadow_decode #(
  parameter int NUM_ELEM = 8,
  parameter int NUM_FU   = 16,
  parameter int IDX_W    = 4
) (
  input  logic [NUM_ELEM-1:0]       en,
  input  logic [NUM_ELEM*IDX_W-1:0] map,
  input  logic [NUM_ELEM-1:0]       keep,
  output logic [NUM_FU-1:0]         die_vec,
  output logic [NUM_FU-1:0]         pass_vec
);
  logic [NUM_FU-1:0] sel [NUM_ELEM];

  for (genvar e = 0; e < NUM_ELEM; e++) begin : g_elem
    always_comb begin
      sel[e] = '0;
      if (en[e]) sel[e][map[e*IDX_W +: IDX_W]] = 1'b1;
    end
  end

  always_comb begin
    die_vec  = '0;
    pass_vec = '0;
    for (int e = 0; e < NUM_ELEM; e++) begin
      if (keep[e]) pass_vec = pass_vec | sel[e];
      else         die_vec  = die_vec  | sel[e];
    end
  end
endmodule

// File: rtl/pred_shadow_unit.sv
module pred_shadow_unit #(
  parameter int NUM_ELEM = 8,
  parameter int NUM_FU   = 16,
  parameter int IDX_W    = (NUM_FU > 1) ? $clog2(NUM_FU) : 1
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      alloc_valid,
  output logic                      alloc_ready,
  input  logic [NUM_ELEM-1:0]       alloc_elem_en,
  input  logic [NUM_ELEM*IDX_W-1:0] alloc_map,
  input  logic                      mask_valid,
  output logic                      mask_ready,
  input  logic [NUM_ELEM-1:0]       mask_bits,
  input  logic                      flush,
  output logic                      busy,
  output logic [NUM_FU-1:0]         go_die,
  output logic [NUM_FU-1:0]         success
);
  logic alloc_fire, decide_fire, kill_all;
  logic [NUM_ELEM-1:0]       en_q;
  logic [NUM_ELEM*IDX_W-1:0] map_q;
  logic [NUM_ELEM-1:0]       keep;
  logic [NUM_FU-1:0]         die_vec, pass_vec;

  pred_shadow_ctrl u_ctrl (
    .clk(clk), .rst_n(rst_n), .alloc_valid(alloc_valid), .mask_valid(mask_valid),
    .flush(flush), .alloc_ready(alloc_ready), .mask_ready(mask_ready), .busy(busy),
    .alloc_fire(alloc_fire), .decide_fire(decide_fire), .decide_kill_all(kill_all)
  );

  pred_shadow_map_reg #(.NUM_ELEM(NUM_ELEM), .IDX_W(IDX_W)) u_map (
    .clk(clk), .rst_n(rst_n), .load(alloc_fire), .en_in(alloc_elem_en),
    .map_in(alloc_map), .en_q(en_q), .map_q(map_q)
  );

  assign keep = kill_all ? '0 : mask_bits;

  pred_shadow_decode #(.NUM_ELEM(NUM_ELEM), .NUM_FU(NUM_FU), .IDX_W(IDX_W)) u_dec (
    .en(en_q), .map(map_q), .keep(keep), .die_vec(die_vec), .pass_vec(pass_vec)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      go_die  <= '0;
      success <= '0;
    end else if (decide_fire) begin
      go_die  <= die_vec;
      success <= pass_vec & ~die_vec;
    end else begin
      go_die  <= '0;
      success <= '0;
    end
  end

  AST_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
    !(|(go_die & success))); // R8
  AST_PULSE_ONCE: assert property (@(posedge clk) disable iff (!rst_n)
    (|go_die || |success) |=> !(|go_die) && !(|success)); // R4
  AST_SUCCESS_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    (|success) |-> $past(mask_valid && mask_ready && !flush)); // R5
  AST_DIE_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    (|go_die) |-> $past(mask_ready && (mask_valid || flush))); // R3
  AST_FLUSH_NO_PASS: assert property (@(posedge clk) disable iff (!rst_n)
    $past(flush && mask_ready) |-> !(|success)); // R7
endmodule

// File: tb/tb_pred_shadow_unit.sv
module tb_pred_shadow_unit;
  localparam int NE = 4;
  localparam int NF = 8;
  localparam int IW = 3;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic alloc_valid = 1'b0, mask_valid = 1'b0, flush = 1'b0;
  logic [NE-1:0] alloc_elem_en = '0, mask_bits = '0;
  logic [NE*IW-1:0] alloc_map = '0;
  logic alloc_ready, mask_ready, busy;
  logic [NF-1:0] go_die, success;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  pred_shadow_unit #(.NUM_ELEM(NE), .NUM_FU(NF)) dut (
    .clk(clk), .rst_n(rst_n), .alloc_valid(alloc_valid), .alloc_ready(alloc_ready),
    .alloc_elem_en(alloc_elem_en), .alloc_map(alloc_map), .mask_valid(mask_valid),
    .mask_ready(mask_ready), .mask_bits(mask_bits), .flush(flush), .busy(busy),
    .go_die(go_die), .success(success)
  );

  task automatic chk(input logic [31:0] act, input logic [31:0] exp, input string tag);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [NF-1:0] expect_vec(input logic [NE-1:0] en,
      input logic [NE*IW-1:0] map, input logic [NE-1:0] m, input bit want_one);
    logic [NF-1:0] v = '0;
    for (int e = 0; e < NE; e++)
      if (en[e] && (m[e] == want_one)) v[map[e*IW +: IW]] = 1'b1;
    return v;
  endfunction

  task automatic do_alloc(input logic [NE-1:0] en, input logic [NE*IW-1:0] map);
    @(negedge clk);
    alloc_valid = 1'b1; alloc_elem_en = en; alloc_map = map;
    @(negedge clk);
    alloc_valid = 1'b0;
    chk(busy, 1, "R2 busy after alloc");
    chk(alloc_ready, 0, "R2 alloc_ready low");
    chk(mask_ready, 1, "R3 mask_ready in wait");
  endtask

  task automatic do_mask(input logic [NE-1:0] m, input bit fl,
      input logic [NE-1:0] en, input logic [NE*IW-1:0] map, input string tag);
    logic [NE-1:0] eff;
    eff = fl ? '0 : m;
    @(negedge clk);
    mask_valid = 1'b1; mask_bits = m; flush = fl;
    @(negedge clk);
    mask_valid = 1'b0; flush = 1'b0;
    chk(go_die, expect_vec(en, map, eff, 1'b0), {tag, " go_die R4"});
    chk(success, expect_vec(en, map, eff, 1'b1), {tag, " success R5"});
    @(negedge clk);
    chk(go_die | success, 0, {tag, " R8 pulse dropped"});
    chk(busy, 0, {tag, " R8 back to idle"});
    chk(alloc_ready, 1, {tag, " R8 ready again"});
  endtask

  task automatic t_reset();
    chk(busy, 0, "R1 busy");
    chk(alloc_ready, 1, "R1 alloc_ready");
    chk(mask_ready, 0, "R1 mask_ready");
    chk(go_die | success, 0, "R1 outputs");
  endtask

  task automatic t_mixed();
    do_alloc(4'b1111, {3'd6, 3'd4, 3'd2, 3'd0});
    do_mask(4'b1010, 1'b0, 4'b1111, {3'd6, 3'd4, 3'd2, 3'd0}, "mixed");
  endtask

  task automatic t_all_ones();
    do_alloc(4'b1111, {3'd1, 3'd3, 3'd5, 3'd7});
    do_mask(4'b1111, 1'b0, 4'b1111, {3'd1, 3'd3, 3'd5, 3'd7}, "ones R5");
  endtask

  task automatic t_unmapped();
    do_alloc(4'b0101, {3'd7, 3'd3, 3'd6, 3'd2});
    do_mask(4'b1011, 1'b0, 4'b0101, {3'd7, 3'd3, 3'd6, 3'd2}, "R6 unmapped");
  endtask

  task automatic t_flush_wait();
    do_alloc(4'b0111, {3'd0, 3'd5, 3'd4, 3'd3});
    do_mask(4'b0000, 1'b1, 4'b0111, {3'd0, 3'd5, 3'd4, 3'd3}, "R7 flush");
  endtask

  task automatic t_flush_and_mask();
    do_alloc(4'b1111, {3'd0, 3'd1, 3'd2, 3'd3});
    do_mask(4'b1111, 1'b1, 4'b1111, {3'd0, 3'd1, 3'd2, 3'd3}, "R7 flush beats mask");
  endtask

  task automatic t_flush_idle();
    @(negedge clk); flush = 1'b1;
    @(negedge clk); flush = 1'b0;
    chk(go_die | success, 0, "R9 no pulse");
    chk(busy, 0, "R9 stays idle");
  endtask

  task automatic t_mask_idle();
    @(negedge clk); mask_valid = 1'b1; mask_bits = 4'b1111;
    @(negedge clk); mask_valid = 1'b0;
    chk(go_die | success, 0, "R3 mask in idle ignored");
    chk(mask_ready, 0, "R3 mask_ready idle");
  endtask

  task automatic t_alloc_busy();
    do_alloc(4'b0011, {3'd0, 3'd0, 3'd6, 3'd5});
    @(negedge clk);
    alloc_valid = 1'b1; alloc_elem_en = 4'b1100; alloc_map = {3'd1, 3'd2, 3'd3, 3'd4};
    @(negedge clk);
    alloc_valid = 1'b0;
    chk(mask_ready, 1, "R2 still waiting");
    do_mask(4'b0010, 1'b0, 4'b0011, {3'd0, 3'd0, 3'd6, 3'd5}, "R2 map kept");
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_mixed();
    t_all_ones();
    t_unmapped();
    t_flush_wait();
    t_flush_and_mask();
    t_flush_idle();
    t_mask_idle();
    t_alloc_busy();
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (5000) @(posedge clk);
        checks++; errors++;
        $display("FAIL watchdog expired");
      end
    join_any
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule